// File: doc/BRIEF.md
# DRAM Power-Up and Training Sequencer

This block takes one memory channel from power-up to a trained, ready state. On a start pulse it holds the DRAM reset output low for a programmed time. It then keeps clock enable blocked for a second programmed time. After that it walks two training steps, write leveling first and then read/write strobe training, and parks in a ready state. Every delay comes from a 32-bit parameter register. Each delay field holds an exponent n, and the time applied is 2^n clock cycles.

A training step ends when the training engine returns a done pulse. If no pulse comes, a watchdog expires and forces the step onward. The watchdog is reloaded at the start of every step. A sticky flag records that at least one step ended on timeout. While write leveling runs, the block emits a write-leveling strobe at a fixed spacing of 16 or 32 cycles. While strobe training runs, it emits read strobes and write strobes separated by a programmed gap. The parameter register is captured when start is accepted, so a write made during a run only applies to the next run.

Top module: `dram_init_seq`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x001E0000, so the gap field at bits 21:17 holds 15 and every other field holds 0. Bits 31:22 and bit 15 always read 0, and writes to them are discarded. Writing all ones reads back 0x003F7FFF.
- R2: `seq_state` encodes idle=0, reset-hold=1, clock-enable block=2, write leveling=3, strobe training=4, ready=5. A start pulse sampled in state 0 or 5 moves to state 1 at that edge. A start pulse in states 1 to 4 is ignored.
- R3: `mem_rst_n` is low in states 0 and 1 and high in all other states. State 1 lasts exactly 2^n cycles, where n is taken from bits 4:0.
- R4: State 2 lasts exactly 2^n cycles, where n is taken from bits 9:5. `mem_cke` is low in states 0 to 2 and high in states 3 to 5.
- R5: States 3 and 4 each last at most 2^n cycles, where n is taken from bits 14:10. The watchdog restarts on entry to each of these states. A step that ends by expiry sets `timed_out`.
- R6: A `step_done` sampled high in state 3 or 4 ends that step at that edge and does not set `timed_out`. This holds even when the watchdog expires in the same cycle. A `step_done` in states 0, 1, 2 or 5 is ignored.
- R7: In state 3, `wl_strobe` pulses in the last cycle of every 16-cycle window when bit 16 is 0, and of every 32-cycle window when bit 16 is 1. The first window begins with the first cycle of the state. The strobe is never high outside state 3.
- R8: In state 4, `dq_rd_strobe` pulses in the first cycle of the state. `dq_wr_strobe` pulses exactly 2^n cycles after each read strobe, where n is taken from bits 21:17. The next read strobe follows in the cycle after each write strobe. Neither strobe is high outside state 4.
- R9: The field values used during a run are those held when start was accepted. Register writes made during the run change no phase length or strobe spacing of that run.
- R10: `ready` is high exactly in state 5. `timed_out` is 0 after reset. It stays set through state 5 and is cleared when the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all logic is on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Parameter register write enable |
| cfg_wdata | input | 32 | Parameter register write data |
| cfg_rdata | output | 32 | Parameter register contents, reserved bits zero |
| start | input | 1 | Starts a sequence from idle or ready |
| step_done | input | 1 | Training step completion pulse |
| mem_rst_n | output | 1 | Active-low DRAM reset |
| mem_cke | output | 1 | DRAM clock enable |
| wl_strobe | output | 1 | Write-leveling command strobe |
| dq_rd_strobe | output | 1 | Read strobe for strobe training |
| dq_wr_strobe | output | 1 | Write strobe for strobe training |
| seq_state | output | 3 | Current sequence state code |
| ready | output | 1 | Sequence complete |
| timed_out | output | 1 | Sticky: a step ended on watchdog expiry |

## Verification
The state code changes at the same rising edge that samples start, step_done or the last cycle of a timer. The bench therefore drives inputs on the falling edge and counts, at each falling edge, how many cycles each state code was present. A phase length is then a count of samples, and a step-done driven at the falling edge of cycle k ends the step after exactly k cycles. The strobes are decoded directly from the state and the counters, so each one is seen in the same sample as the state cycle it belongs to. The bench records strobe counts and the cycle index of the first read strobe and the first write strobe. It compares these with the values computed from each vector's exponents, and then checks `ready` and `timed_out` in the cycles that follow the entry to state 5.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_RST_HOLD  = 3'd1,
      ST_CKE_BLOCK = 3'd2,
      ST_WR_LEVEL  = 3'd3,
      ST_DQS_TRAIN = 3'd4,
      ST_READY     = 3'd5
   } seq_state_e;

   localparam int CFG_W   = 32;
   localparam int EXP_W   = 5;

   // field positions inside the parameter register
   localparam int RST_LSB = 0;
   localparam int CKE_LSB = 5;
   localparam int WD_LSB  = 10;
   localparam int WL_BIT  = 16;
   localparam int GAP_LSB = 17;

   localparam logic [CFG_W-1:0] CFG_RESET = 32'h001E_0000;
   localparam logic [CFG_W-1:0] CFG_WMASK = 32'h003F_7FFF;

endpackage

// File: rtl/dis_cfg_reg.sv
module dis_cfg_reg #(
   parameter int          W     = 32,
   parameter logic [W-1:0] RST  = '0,
   parameter logic [W-1:0] MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   if ((RST & ~MASK) != '0) begin : g_bad_reset
      $error("dis_cfg_reg: reset value sets a reserved bit");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST;
      else if (we) q <= wdata & MASK;
   end

endmodule

// File: rtl/dis_pow2_timer.sv
module dis_pow2_timer #(
   parameter int CNT_W = 32,
   parameter int EXP_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [EXP_W-1:0] exp_n,
   output logic             last
);

   if (CNT_W < (1 << EXP_W)) begin : g_too_narrow
      $error("dis_pow2_timer: CNT_W cannot hold 2^(2^EXP_W - 1)");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim_m1;

   always_comb begin
      lim_m1 = (CNT_W'(1) << exp_n) - CNT_W'(1);
      last   = en && (cnt_q == lim_m1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (clr)  cnt_q <= '0;
      else if (last) cnt_q <= '0;
      else if (en)   cnt_q <= cnt_q + CNT_W'(1);
   end

endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
   import dram_init_pkg::*;
#(
   parameter int CNT_W        = 32,
   parameter int WL_SHORT_EXP = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] cfg_rdata,
   input  logic             start,
   input  logic             step_done,
   output logic             mem_rst_n,
   output logic             mem_cke,
   output logic             wl_strobe,
   output logic             dq_rd_strobe,
   output logic             dq_wr_strobe,
   output logic [2:0]       seq_state,
   output logic             ready,
   output logic             timed_out
);

   localparam int WL_LONG_EXP = WL_SHORT_EXP + 1;
   localparam logic [EXP_W-1:0] WL_S = EXP_W'(WL_SHORT_EXP);
   localparam logic [EXP_W-1:0] WL_L = EXP_W'(WL_LONG_EXP);

   if (WL_LONG_EXP >= (1 << EXP_W)) begin : g_bad_wl
      $error("dram_init_seq: write-leveling spacing exponent out of range");
   end

   seq_state_e       state_q, state_d;
   logic [EXP_W-1:0] snap_rst, snap_cke, snap_wd, snap_gap;
   logic             snap_wl;
   logic             dq_ph_q;
   logic             start_ok, in_train, chg, timeout_hit;
   logic             step_en, step_last, pace_en, pace_clr, pace_last;
   logic [EXP_W-1:0] step_exp, pace_exp;

   dis_cfg_reg #(.W(CFG_W), .RST(CFG_RESET), .MASK(CFG_WMASK)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .q(cfg_rdata)
   );

   always_comb begin
      start_ok    = start && (state_q == ST_IDLE || state_q == ST_READY);
      in_train    = (state_q == ST_WR_LEVEL) || (state_q == ST_DQS_TRAIN);
      timeout_hit = in_train && step_last && !step_done;
      state_d     = state_q;
      case (state_q)
         ST_IDLE, ST_READY: if (start_ok)               state_d = ST_RST_HOLD;
         ST_RST_HOLD:       if (step_last)              state_d = ST_CKE_BLOCK;
         ST_CKE_BLOCK:      if (step_last)              state_d = ST_WR_LEVEL;
         ST_WR_LEVEL:       if (step_done || step_last) state_d = ST_DQS_TRAIN;
         ST_DQS_TRAIN:      if (step_done || step_last) state_d = ST_READY;
         default:                                       state_d = ST_IDLE;
      endcase
      chg = (state_d != state_q);
   end

   // one timer serves the reset hold, the clock-enable block and the watchdog
   always_comb begin
      case (state_q)
         ST_RST_HOLD:  step_exp = snap_rst;
         ST_CKE_BLOCK: step_exp = snap_cke;
         default:      step_exp = snap_wd;
      endcase
      step_en  = (state_q != ST_IDLE) && (state_q != ST_READY);
      pace_exp = (state_q == ST_WR_LEVEL) ? (snap_wl ? WL_L : WL_S) : snap_gap;
      pace_en  = (state_q == ST_WR_LEVEL) || (state_q == ST_DQS_TRAIN && dq_ph_q);
      pace_clr = chg || (state_q == ST_DQS_TRAIN && !dq_ph_q);
   end

   dis_pow2_timer #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_step_tmr (
      .clk(clk), .rst_n(rst_n), .clr(chg), .en(step_en),
      .exp_n(step_exp), .last(step_last)
   );

   dis_pow2_timer #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_pace_tmr (
      .clk(clk), .rst_n(rst_n), .clr(pace_clr), .en(pace_en),
      .exp_n(pace_exp), .last(pace_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         snap_rst  <= '0;
         snap_cke  <= '0;
         snap_wd   <= '0;
         snap_wl   <= 1'b0;
         snap_gap  <= '0;
         timed_out <= 1'b0;
         dq_ph_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (start_ok) begin
            snap_rst  <= cfg_rdata[RST_LSB +: EXP_W];
            snap_cke  <= cfg_rdata[CKE_LSB +: EXP_W];
            snap_wd   <= cfg_rdata[WD_LSB  +: EXP_W];
            snap_wl   <= cfg_rdata[WL_BIT];
            snap_gap  <= cfg_rdata[GAP_LSB +: EXP_W];
            timed_out <= 1'b0;
         end else if (timeout_hit) begin
            timed_out <= 1'b1;
         end
         if (chg)                           dq_ph_q <= 1'b0;
         else if (state_q == ST_DQS_TRAIN)  dq_ph_q <= dq_ph_q ? !pace_last : 1'b1;
      end
   end

   always_comb begin
      seq_state    = state_q;
      mem_rst_n    = (state_q != ST_IDLE) && (state_q != ST_RST_HOLD);
      mem_cke      = (state_q == ST_WR_LEVEL) || (state_q == ST_DQS_TRAIN)
                     || (state_q == ST_READY);
      ready        = (state_q == ST_READY);
      wl_strobe    = (state_q == ST_WR_LEVEL) && pace_last;
      dq_rd_strobe = (state_q == ST_DQS_TRAIN) && !dq_ph_q;
      dq_wr_strobe = (state_q == ST_DQS_TRAIN) && dq_ph_q && pace_last;
   end

   // R3
   rst_before_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_rst_n |-> !mem_cke);

   // R6
   done_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WR_LEVEL && step_done) |=> state_q == ST_DQS_TRAIN);

   // R6
   done_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RST_HOLD && step_done && !step_last) |=> state_q == ST_RST_HOLD);

   // R2
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CKE_BLOCK && start && !step_last) |=> state_q == ST_CKE_BLOCK);

   // R7
   wl_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wl_strobe |-> state_q == ST_WR_LEVEL);

   // R8
   rd_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_wr_strobe |=> (dq_rd_strobe || state_q != ST_DQS_TRAIN));

   // R5
   timeout_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timed_out) |-> ($past(state_q) == ST_WR_LEVEL || $past(state_q) == ST_DQS_TRAIN));

   // R10
   ready_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (mem_cke && mem_rst_n));

endmodule

// File: tb/dram_init_seq_bench.sv
`timescale 1ns/1ps
module dram_init_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        start = 1'b0;
   logic        step_done = 1'b0;
   logic        mem_rst_n, mem_cke, wl_strobe, dq_rd_strobe, dq_wr_strobe;
   logic [2:0]  seq_state;
   logic        ready, timed_out;

   int tests = 0;
   int fails = 0;

   always #4 clk = ~clk;

   dram_init_seq u_dram_init_seq (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .start(start), .step_done(step_done),
      .mem_rst_n(mem_rst_n), .mem_cke(mem_cke), .wl_strobe(wl_strobe),
      .dq_rd_strobe(dq_rd_strobe), .dq_wr_strobe(dq_wr_strobe),
      .seq_state(seq_state), .ready(ready), .timed_out(timed_out)
   );

   // columns: rst_exp, cke_exp, wd_exp, wl_sel, gap_exp, done_at_wl, done_at_dq, junk
   localparam int NV = 5;
   localparam int VEC [NV][8] = '{
      '{2, 3, 6, 0, 2,   0,  0, 0},
      '{0, 0, 5, 1, 0,  10,  7, 1},
      '{4, 1, 7, 0, 4, 128,  0, 0},
      '{1, 2, 7, 1, 3, 100, 50, 1},
      '{3, 0, 4, 1, 1,   0,  5, 0}
   };

   task automatic chk(input string req, input longint act, input longint exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic write_cfg(input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic run_vec(input int v);
      int r = VEC[v][0], c = VEC[v][1], w = VEC[v][2], sel = VEC[v][3];
      int q = VEC[v][4], kwl = VEC[v][5], kdq = VEC[v][6], junk = VEC[v][7];
      int n_rh = 0, n_cke = 0, n_wl = 0, n_dq = 0, n_wls = 0, n_rd = 0, n_wr = 0;
      int first_rd = -1, first_wr = -1, bad_pins = 0, bad_strb = 0;
      int wlim = 1 << w;
      int e_wl = (kwl != 0 && kwl <= wlim) ? kwl : wlim;
      int e_dq = (kdq != 0 && kdq <= wlim) ? kdq : wlim;
      int e_to = (e_wl == kwl && e_dq == kdq) ? 0 : 1;
      int per = sel ? 32 : 16;
      int pp = (1 << q) + 1;
      logic [31:0] word;
      word = 32'(r) | (32'(c) << 5) | (32'(w) << 10) | (32'(sel) << 16) | (32'(q) << 17);
      write_cfg(word);
      start = 1'b1;
      for (int it = 0; it < 5000; it++) begin
         @(negedge clk);
         start = 1'b0;
         cfg_we = 1'b0;
         if (seq_state == 3'd5) break;
         if (mem_rst_n != (seq_state >= 3'd2)) bad_pins++;
         if (mem_cke != (seq_state >= 3'd3)) bad_pins++;
         if (seq_state != 3'd3 && wl_strobe) bad_strb++;
         if (seq_state != 3'd4 && (dq_rd_strobe || dq_wr_strobe)) bad_strb++;
         case (seq_state)
            3'd1: n_rh++;
            3'd2: n_cke++;
            3'd3: begin n_wl++; if (wl_strobe) n_wls++; end
            3'd4: begin
               n_dq++;
               if (dq_rd_strobe) begin n_rd++; if (first_rd < 0) first_rd = n_dq; end
               if (dq_wr_strobe) begin n_wr++; if (first_wr < 0) first_wr = n_dq; end
            end
            default: ;
         endcase
         step_done = (seq_state == 3'd3 && n_wl == kwl) || (seq_state == 3'd4 && n_dq == kdq)
                     || (junk != 0 && (seq_state == 3'd1 || seq_state == 3'd2));
         if (junk != 0 && seq_state == 3'd2) start = 1'b1;
         if (junk != 0 && seq_state == 3'd1) begin cfg_we = 1'b1; cfg_wdata = '0; end
      end
      step_done = 1'b0;
      chk($sformatf("R3 v%0d reset hold length", v), n_rh, 1 << r);
      chk($sformatf("R4 v%0d cke block length", v), n_cke, 1 << c);
      chk($sformatf("R5 R6 v%0d write-level length", v), n_wl, e_wl);
      chk($sformatf("R5 R6 v%0d strobe-train length", v), n_dq, e_dq);
      chk($sformatf("R3 R4 v%0d reset/cke pins per state", v), bad_pins, 0);
      chk($sformatf("R7 R8 v%0d strobes outside their state", v), bad_strb, 0);
      chk($sformatf("R7 v%0d write-level strobe count", v), n_wls, e_wl / per);
      chk($sformatf("R8 v%0d read strobe count", v), n_rd, (e_dq + pp - 1) / pp);
      chk($sformatf("R8 v%0d write strobe count", v), n_wr, e_dq / pp);
      chk($sformatf("R8 v%0d first read cycle", v), first_rd, 1);
      if (e_dq >= pp) chk($sformatf("R8 v%0d read-to-write gap", v), first_wr - first_rd, 1 << q);
      chk($sformatf("R10 v%0d ready", v), ready, 1);
      chk($sformatf("R5 R10 v%0d timeout flag", v), timed_out, e_to);
      repeat (3) @(negedge clk);
      chk($sformatf("R10 v%0d flag sticky in ready", v), timed_out, e_to);
      chk($sformatf("R10 v%0d still ready", v), {29'd0, seq_state}, 5);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog: run did not end in time, actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // reset state
      chk("R1 reset value", cfg_rdata, 32'h001E_0000);
      chk("R2 idle after reset", seq_state, 0);
      chk("R3 reset held in idle", mem_rst_n, 0);
      chk("R4 cke low in idle", mem_cke, 0);
      chk("R10 no ready after reset", ready, 0);
      chk("R10 no timeout after reset", timed_out, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2 stays idle without start", seq_state, 0);
      // reserved bits
      write_cfg(32'hFFFF_FFFF);
      chk("R1 reserved bits read zero", cfg_rdata, 32'h003F_7FFF);
      write_cfg(32'h0000_0000);
      chk("R1 all fields clear", cfg_rdata, 0);
      // done pulse in idle ignored
      step_done = 1'b1;
      @(negedge clk);
      step_done = 1'b0;
      @(negedge clk);
      chk("R6 done ignored in idle", seq_state, 0);
      // vector table; rows with junk also exercise R2 ignore and R9 snapshot
      for (int v = 0; v < NV; v++) run_vec(v);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule